// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block sits between a host memory bus and a battery-backed static RAM. It decides when the RAM may be selected, using two digital flags from external supply comparators. The first flag, `pf_low`, means the supply is below the power-fail threshold. The second flag, `so_low`, means the supply is below the battery switchover threshold. The block also watches the host's chip enable, so it can tell whether an access is in progress when power starts to fail.

When power drops, the block does not cut off an access that is already running. It gives that access a grace window, and once the window ends the RAM is protected no matter what. When power comes back, protection is held for a long recovery time so the host can settle. The block also controls the battery path: the battery stays isolated until main power has been seen for the first time. After that, the battery feeds the storage whenever the supply is below the switchover threshold.

The state machine has four states:
- `ST_DOWN`: protected, supply failed.
- `ST_RECOVER`: protected, counting the recovery hold.
- `ST_ACTIVE`: normal access.
- `ST_GRACE`: a started access may finish.

It has six transitions:
- `ST_DOWN` to `ST_RECOVER` when `pf_low` clears.
- `ST_RECOVER` to `ST_DOWN` when `pf_low` returns.
- `ST_RECOVER` to `ST_ACTIVE` when the hold expires.
- `ST_ACTIVE` to `ST_GRACE` on `pf_low` while `ce_n` is low.
- `ST_ACTIVE` to `ST_DOWN` on `pf_low` while `ce_n` is high.
- `ST_GRACE` to `ST_DOWN` when `ce_n` rises or the grace timer expires.

Top module: `pfwp_seq`

## Requirements
- R1: During reset and after it, while `pf_low` stays 1, the block is in `ST_DOWN` with `wp`=1, `mem_ce_n`=1 and `dq_oe`=0.
- R2: If `pf_low` is sampled 1 in `ST_ACTIVE` while `ce_n`=1, `wp` is 1 after that same clock edge.
- R3: If `pf_low` is sampled 1 in `ST_ACTIVE` while `ce_n`=0, `wp` stays 0 and `mem_ce_n` follows `ce_n`. `wp` rises at the first edge that samples `ce_n`=1.
- R4: The grace window lasts at most `WPT_CYC` cycles. `wp` is 1 after the `WPT_CYC`-th edge following the edge that entered `ST_GRACE`, even if `ce_n` is still 0.
- R5: If `pf_low` returns to 0 during the grace window, protection is still applied when the window ends. The full recovery hold follows before `wp` clears.
- R6: Once `pf_low` is 0 in `ST_DOWN`, `wp` stays 1 for `REC_CYC`+1 edges (the move to `ST_RECOVER` plus `REC_CYC` hold cycles). It then falls to 0.
- R7: A return of `pf_low`=1 during `ST_RECOVER` sends the block back to `ST_DOWN`. The next release restarts the full `REC_CYC` hold.
- R8: While `wp`=1, the host inputs are ignored: `mem_ce_n`=1, `mem_we_n`=1 and `dq_oe`=0 for any `ce_n`, `we_n`, `oe_n`.
- R9: In `ST_ACTIVE`, `mem_ce_n`=`ce_n` and `mem_we_n`=`we_n | ce_n`. `dq_oe`=1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R10: With `ce_n`=1 the RAM is deselected: `mem_ce_n`=1, `mem_we_n`=1, `dq_oe`=0.
- R11: From reset until `so_low` has been sampled 0 at least once, `bat_conn`=0 even while `so_low`=1.
- R12: After main power has been seen once, `bat_conn` equals `so_low` (1 = battery feeds storage, 0 = main supply).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_low | input | 1 | 1 = supply below power-fail threshold |
| so_low | input | 1 | 1 = supply below battery switchover threshold |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to the RAM array |
| mem_we_n | output | 1 | Gated write enable to the RAM array |
| dq_oe | output | 1 | 1 = data bus drivers enabled for a read |
| wp | output | 1 | 1 = RAM write-protected and deselected |
| bat_conn | output | 1 | 1 = battery connected to storage supply |

## Verification
On every cycle, the assertions check a set of local safety properties:
- protection gates all three host strobes;
- deselect through `ce_n` hides the data bus;
- an idle bus is protected one edge after power-fail;
- protection never lifts while `pf_low` is high;
- a counter bounds the unprotected time after power-fail to the grace window;
- a counter makes sure no release happens before `REC_CYC` clean cycles;
- the battery is never connected before main power has been seen.

The exact timing needs the bench's scenarios. This covers the cycle where the grace window closes for each access length, including accesses that outlast it. It also covers the full recovery after a supply that comes back mid-grace, the restart after a glitch in the hold, and the read/write pass-through in `ST_ACTIVE`.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    typedef enum logic [1:0] {
        ST_DOWN    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_GRACE   = 2'd3
    } pfwp_state_e;

endpackage

// File: rtl/pfwp_timer.sv
module pfwp_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pfwp_supply.sv
module pfwp_supply (
    input  logic clk,
    input  logic rst_n,
    input  logic so_low,
    output logic bat_conn
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!so_low) begin
            armed <= 1'b1;
        end
    end

    assign bat_conn = armed & so_low;

endmodule

// File: rtl/pfwp_fsm.sv
module pfwp_fsm
    import pfwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pf_low,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic tmr_done,
    output logic load_grace,
    output logic load_rec,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic dq_oe,
    output logic wp
);

    pfwp_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DOWN;
        end else begin
            state <= state_nx;
        end
    end

    // next state and timer loads
    always_comb begin
        state_nx   = state;
        load_grace = 1'b0;
        load_rec   = 1'b0;
        unique case (state)
            ST_DOWN: begin
                if (!pf_low) begin
                    state_nx = ST_RECOVER;
                    load_rec = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (pf_low) begin
                    state_nx = ST_DOWN;
                end else if (tmr_done) begin
                    state_nx = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (pf_low) begin
                    if (!ce_n) begin
                        state_nx   = ST_GRACE;
                        load_grace = 1'b1;
                    end else begin
                        state_nx = ST_DOWN;
                    end
                end
            end
            ST_GRACE: begin
                if (ce_n || tmr_done) begin
                    state_nx = ST_DOWN;
                end
            end
            default: state_nx = ST_DOWN;
        endcase
    end

    // outputs
    always_comb begin
        wp       = (state == ST_DOWN) || (state == ST_RECOVER);
        mem_ce_n = ce_n | wp;
        mem_we_n = we_n | mem_ce_n;
        dq_oe    = !mem_ce_n && !oe_n && we_n;
    end

endmodule

// File: rtl/pfwp_seq.sv
module pfwp_seq #(
    parameter int WPT_CYC = 5000,
    parameter int REC_CYC = 5000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_low,
    input  logic so_low,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic dq_oe,
    output logic wp,
    output logic bat_conn
);

    localparam int MAXC = (WPT_CYC > REC_CYC) ? WPT_CYC : REC_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] GRACE_LD = CW'(WPT_CYC - 1);
    localparam logic [CW-1:0] REC_LD   = CW'(REC_CYC - 1);

    logic          load_grace;
    logic          load_rec;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;

    assign tmr_val = load_grace ? GRACE_LD : REC_LD;

    pfwp_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_grace | load_rec),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pfwp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pf_low     (pf_low),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .tmr_done   (tmr_done),
        .load_grace (load_grace),
        .load_rec   (load_rec),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .dq_oe      (dq_oe),
        .wp         (wp)
    );

    pfwp_supply u_supply (
        .clk      (clk),
        .rst_n    (rst_n),
        .so_low   (so_low),
        .bat_conn (bat_conn)
    );

endmodule

// File: rtl/pfwp_seq_chk.sv
module pfwp_seq_chk #(
    parameter int WPT_CYC = 5000,
    parameter int REC_CYC = 5000000
) (
    input logic clk,
    input logic rst_n,
    input logic pf_low,
    input logic so_low,
    input logic ce_n,
    input logic mem_ce_n,
    input logic mem_we_n,
    input logic dq_oe,
    input logic wp,
    input logic bat_conn
);

    localparam int GW = $clog2(WPT_CYC + 2) + 1;
    localparam int RW = $clog2(REC_CYC + 2) + 1;
    localparam logic [GW-1:0] G_MAX = GW'(WPT_CYC + 1);
    localparam logic [RW-1:0] R_MAX = RW'(REC_CYC + 1);

    logic [GW-1:0] g_cnt;
    logic [RW-1:0] ok_cnt;
    logic          seen_main;

    // unprotected cycles since power-fail was seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_cnt <= '0;
        end else if (!wp && (pf_low || g_cnt != '0)) begin
            if (g_cnt != G_MAX) g_cnt <= g_cnt + 1'b1;
        end else begin
            g_cnt <= '0;
        end
    end

    // consecutive clean-supply cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_cnt <= '0;
        end else if (pf_low) begin
            ok_cnt <= '0;
        end else if (ok_cnt != R_MAX) begin
            ok_cnt <= ok_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_main <= 1'b0;
        end else if (!so_low) begin
            seen_main <= 1'b1;
        end
    end

    assert_idle_fail_protects_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_low && ce_n && !wp) |=> wp);

    assert_grace_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wp |-> (g_cnt <= GW'(WPT_CYC)));

    assert_no_early_unprotect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && pf_low) |=> wp);

    assert_full_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wp) |-> (ok_cnt >= RW'(REC_CYC)));

    assert_inputs_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> (mem_ce_n && mem_we_n && !dq_oe));

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (mem_ce_n && mem_we_n && !dq_oe));

    assert_battery_isolated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_main |-> !bat_conn);

    assert_battery_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bat_conn |-> so_low);

endmodule

bind pfwp_seq pfwp_seq_chk #(.WPT_CYC(WPT_CYC), .REC_CYC(REC_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pf_low   (pf_low),
    .so_low   (so_low),
    .ce_n     (ce_n),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .dq_oe    (dq_oe),
    .wp       (wp),
    .bat_conn (bat_conn)
);

// File: tb/pfwp_seq_bench.sv
module pfwp_seq_bench;

    localparam int W = 8;
    localparam int R = 20;

    logic clk = 1'b0;
    logic rst_n, pf_low, so_low, ce_n, we_n, oe_n;
    logic mem_ce_n, mem_we_n, dq_oe, wp, bat_conn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pfwp_seq #(.WPT_CYC(W), .REC_CYC(R)) u_pfwp_seq (
        .clk(clk), .rst_n(rst_n), .pf_low(pf_low), .so_low(so_low),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .dq_oe(dq_oe),
        .wp(wp), .bat_conn(bat_conn)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // R6: release supply from ST_DOWN, wp held REC hold then clears
    task automatic recover_run(input string tag);
        ce_n = 1; we_n = 1; oe_n = 1;
        pf_low = 0;
        for (int k = 1; k <= R + 1; k++) begin
            @(negedge clk);
            chk(tag, wp, (k <= R));
        end
    endtask

    // R2/R3/R4/R5: power-fail with access of length d (0 = idle bus)
    task automatic grace_run(input int d, input int drop_at);
        int g;
        int last;
        g = (d < W) ? d : W;
        last = (drop_at > 0) ? (g + R + 2) : (W + 3);
        ce_n = (d == 0); oe_n = 0; we_n = 1;
        @(negedge clk);
        pf_low = 1;
        for (int k = 1; k <= last; k++) begin
            int  m;
            logic wpe, cen, mce;
            @(negedge clk);
            m = k - 1;
            if (drop_at > 0) wpe = (m >= g) && (m < g + 1 + R);
            else             wpe = (m >= g);
            cen = (d == 0) || (k > d);
            mce = wpe | cen;
            if (drop_at > 0)   chk("R5 wp after mid-grace return", wp, wpe);
            else if (d == 0)   chk("R2 idle bus protect", wp, wpe);
            else if (d < W)    chk("R3 access finishes", wp, wpe);
            else               chk("R4 grace cap", wp, wpe);
            chk("R3 mem_ce_n during grace", mem_ce_n, mce);
            chk("R8 dq_oe gated", dq_oe, !mce);
            if (k == d) ce_n = 1;
            if (k == drop_at) pf_low = 0;
        end
        ce_n = 1; oe_n = 1;
        if (drop_at == 0) recover_run("R6 recovery after grace");
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; pf_low = 1; so_low = 1; ce_n = 1; we_n = 1; oe_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset wp", wp, 1);
        chk("R1 reset mem_ce_n", mem_ce_n, 1);
        chk("R1 reset dq_oe", dq_oe, 0);
        chk("R11 reset bat_conn", bat_conn, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 held while pf_low", wp, 1);
        chk("R11 no battery before main", bat_conn, 0);
        ce_n = 0; we_n = 0; oe_n = 0;
        @(negedge clk);
        chk("R8 ce ignored", mem_ce_n, 1);
        chk("R8 we ignored", mem_we_n, 1);
        chk("R8 oe ignored", dq_oe, 0);
        we_n = 1;
        @(negedge clk);
        chk("R8 read ignored", dq_oe, 0);
        ce_n = 1; oe_n = 1;
        so_low = 0;
        @(negedge clk);
        chk("R11 main supply", bat_conn, 0);
        recover_run("R6 first power-up hold");

        // R9/R10 pass-through in ST_ACTIVE
        ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk);
        chk("R9 read mem_ce_n", mem_ce_n, 0);
        chk("R9 read dq_oe", dq_oe, 1);
        chk("R9 read mem_we_n", mem_we_n, 1);
        we_n = 0; oe_n = 1;
        @(negedge clk);
        chk("R9 write mem_we_n", mem_we_n, 0);
        chk("R9 write dq_oe", dq_oe, 0);
        oe_n = 0;
        @(negedge clk);
        chk("R9 write with oe low dq_oe", dq_oe, 0);
        ce_n = 1;
        @(negedge clk);
        chk("R10 deselect mem_ce_n", mem_ce_n, 1);
        chk("R10 deselect mem_we_n", mem_we_n, 1);
        chk("R10 deselect dq_oe", dq_oe, 0);
        ce_n = 1; we_n = 1; oe_n = 1;
        @(negedge clk);

        // sweep access lengths across the grace window
        for (int d = 0; d <= W + 2; d++) grace_run(d, 0);
        // supply returns during grace
        grace_run(3, 2);
        grace_run(W + 1, 2);

        // R7: glitch during recovery restarts the hold
        pf_low = 1;
        @(negedge clk);
        chk("R2 idle fail", wp, 1);
        pf_low = 0;
        repeat (5) @(negedge clk);
        chk("R7 in hold", wp, 1);
        pf_low = 1;
        repeat (2) @(negedge clk);
        chk("R7 back down", wp, 1);
        recover_run("R7 restarted hold");

        // battery after arming
        so_low = 1;
        @(negedge clk);
        chk("R12 battery connected", bat_conn, 1);
        so_low = 0;
        @(negedge clk);
        chk("R12 battery released", bat_conn, 0);

        finish_run();
    end

endmodule